// File: doc/BRIEF.md
# Atomic swap lock unit

This unit fronts a small register-based memory that holds lock words, and it is shared by several requesters. Each requester presents one operation at a time: a load, a store, or a swap. A swap returns the word currently held at an address and writes the requester's new word there as one indivisible operation. Because the read half and the write half happen together, no other requester can slip an access in between. Two requesters racing for the same lock therefore cannot both see it as free.

A lock word of 0 means the lock is free, and 1 means it is held. To acquire a lock, a requester swaps in 1. It owns the lock only if the swap returns 0, and otherwise it tries again. To release the lock, it stores 0. A round-robin arbiter accepts one request per cycle. Acceptance is signalled to the requester in the same cycle the request is presented, and a requester that is not accepted holds its request until it is.

Top module: `swap_lock_unit`

## Requirements
- R1: After reset, every memory word reads as 0, no response is valid, and no grant is raised while no request is presented.
- R2: In any cycle, at most one grant is raised, and only to a requester presenting a request. A grant is raised whenever at least one request is presented.
- R3: Arbitration is round-robin. After requester i is granted, the search for the next grant starts at requester i+1 (wrapping), so with all requesters continuously requesting, grants rotate 0,1,2,3,0,...
- R4: A load (op code 2'b00) returns the addressed word and leaves memory unchanged.
- R5: A store (op code 2'b01) writes the request's data to the addressed word and responds with data 0.
- R6: A swap (op code 2'b10) returns the word held before the operation and leaves the request's data in that word; the next access to the address sees the new word.
- R7: When two requesters present swaps of 1 to the same free lock word in the same cycle, exactly one of them receives 0 and the other receives 1.
- R8: The response arrives exactly one cycle after the grant. The valid bit rises only for the granted requester (at most one bit set), for a single cycle.
- R9: Op code 2'b11 behaves as a load: it returns the addressed word and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_REQ | Request present, one bit per requester |
| reqOp | input | 2*NUM_REQ | Op code per requester (2 bits each, requester 0 in the low bits) |
| reqAddr | input | ADDR_W*NUM_REQ | Word address per requester |
| reqWdata | input | DATA_W*NUM_REQ | Store or swap data per requester |
| reqGrant | output | NUM_REQ | Request accepted this cycle (one-hot or zero) |
| rspValid | output | NUM_REQ | Response valid for the requester granted last cycle |
| rspData | output | DATA_W | Response word (old word for load or swap, 0 for store) |

## Verification
The two functions that can fall into the same cycle are a swap and a competing swap to the same lock word. The bench provokes this by having two requesters present swaps of 1 to a free lock on the same clock. The loser holds its request into the next cycle. The bench then judges the outcome from the two responses: exactly one must carry 0, the other must carry 1, and only one grant may be raised in each cycle.

// File: rtl/swap_lock_pkg.sv
package swap_lock_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_SWAP  = 2'b10,
    OP_PEEK  = 2'b11
  } lockOp_e;

  // strobes from control to datapath for the accepted operation
  typedef struct packed {
    logic fire;   // one operation accepted this cycle
    logic wrEn;   // write the request data into the addressed word
    logic rdRet;  // return the addressed word in the response
  } dpStrobe_t;

endpackage

// File: rtl/swap_rr_arbiter.sv
module swap_rr_arbiter #(
  parameter int NUM_REQ = 4,
  localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] valid,
  output logic [NUM_REQ-1:0] grant,
  output logic [IDX_W-1:0]   who,
  output logic               any
);

  logic [IDX_W-1:0] startPtr;

  always_comb begin
    int unsigned cand;
    grant = '0;
    who   = '0;
    any   = 1'b0;
    for (int k = 0; k < NUM_REQ; k++) begin
      cand = (int'(startPtr) + k) % NUM_REQ;
      if (!any && valid[cand]) begin
        any         = 1'b1;
        grant[cand] = 1'b1;
        who         = IDX_W'(cand);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startPtr <= '0;
    end else if (any) begin
      startPtr <= (int'(who) == NUM_REQ - 1) ? '0 : IDX_W'(int'(who) + 1);
    end
  end

  // R2
  single_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));

  // R2
  grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grant & ~valid) == '0);

  // R2
  no_idle_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (valid != '0) |-> (grant != '0));

  // R3
  generate
    for (genvar g = 0; g < NUM_REQ; g++) begin : gRot
      localparam int NXT = (g + 1) % NUM_REQ;
      rr_rotate_chk: assert property (@(posedge clk) disable iff (!rstN)
        grant[g] |=> (valid[NXT] -> grant[NXT]));
    end
  endgenerate

endmodule

// File: rtl/swap_ctrl.sv
module swap_ctrl
  import swap_lock_pkg::*;
#(
  parameter int NUM_REQ = 4,
  localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_REQ-1:0]   reqValid,
  input  logic [2*NUM_REQ-1:0] reqOp,
  output logic [NUM_REQ-1:0]   reqGrant,
  output logic [IDX_W-1:0]     who,
  output dpStrobe_t            strobe
);

  logic    any;
  lockOp_e opSel;

  swap_rr_arbiter #(.NUM_REQ(NUM_REQ)) i_arb (
    .clk   (clk),
    .rstN  (rstN),
    .valid (reqValid),
    .grant (reqGrant),
    .who   (who),
    .any   (any)
  );

  always_comb begin
    opSel        = lockOp_e'(reqOp[int'(who)*2 +: 2]);
    strobe.fire  = any;
    strobe.wrEn  = any && (opSel == OP_STORE || opSel == OP_SWAP);
    strobe.rdRet = any && (opSel != OP_STORE);
  end

endmodule

// File: rtl/swap_datapath.sv
module swap_datapath
  import swap_lock_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 8,
  localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpStrobe_t                 strobe,
  input  logic [IDX_W-1:0]          who,
  input  logic [ADDR_W*NUM_REQ-1:0] reqAddr,
  input  logic [DATA_W*NUM_REQ-1:0] reqWdata,
  output logic [NUM_REQ-1:0]        rspValid,
  output logic [DATA_W-1:0]         rspData
);

  logic [DATA_W-1:0] lockMem [DEPTH];
  logic [ADDR_W-1:0] selAddr;
  logic [DATA_W-1:0] selData;

  always_comb begin
    selAddr = reqAddr[int'(who)*ADDR_W +: ADDR_W];
    selData = reqWdata[int'(who)*DATA_W +: DATA_W];
  end

  // read and write of one word in the same edge: the swap is indivisible
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) lockMem[i] <= '0;
      rspValid <= '0;
      rspData  <= '0;
    end else begin
      rspValid <= strobe.fire ? (NUM_REQ'(1) << who) : '0;
      rspData  <= (strobe.fire && strobe.rdRet) ? lockMem[selAddr] : '0;
      if (strobe.fire && strobe.wrEn) lockMem[selAddr] <= selData;
    end
  end

  // R8
  rsp_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rspValid));

  // R8
  rsp_follows_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire |=> (rspValid != '0));

  // R5
  store_rsp_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fire && !strobe.rdRet) |=> (rspData == '0));

  // R6
  swap_old_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fire && strobe.rdRet && strobe.wrEn) |=> (rspData == $past(lockMem[selAddr])));

endmodule

// File: rtl/swap_lock_unit.sv
module swap_lock_unit
  import swap_lock_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_REQ-1:0]        reqValid,
  input  logic [2*NUM_REQ-1:0]      reqOp,
  input  logic [ADDR_W*NUM_REQ-1:0] reqAddr,
  input  logic [DATA_W*NUM_REQ-1:0] reqWdata,
  output logic [NUM_REQ-1:0]        reqGrant,
  output logic [NUM_REQ-1:0]        rspValid,
  output logic [DATA_W-1:0]         rspData
);

  localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

  dpStrobe_t        strobe;
  logic [IDX_W-1:0] who;

  swap_ctrl #(.NUM_REQ(NUM_REQ)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .reqGrant (reqGrant),
    .who      (who),
    .strobe   (strobe)
  );

  swap_datapath #(.NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .who      (who),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .rspValid (rspValid),
    .rspData  (rspData)
  );

endmodule

// File: tb/test_swap_lock_unit.sv
module test_swap_lock_unit;

  localparam int N = 4;
  localparam int A = 3;
  localparam int D = 8;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [N-1:0]   reqValid = '0;
  logic [2*N-1:0] reqOp = '0;
  logic [A*N-1:0] reqAddr = '0;
  logic [D*N-1:0] reqWdata = '0;
  logic [N-1:0]   reqGrant;
  logic [N-1:0]   rspValid;
  logic [D-1:0]   rspData;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  swap_lock_unit #(.NUM_REQ(N), .ADDR_W(A), .DATA_W(D)) i_swap_lock_unit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqGrant(reqGrant),
    .rspValid(rspValid), .rspData(rspData)
  );

  // vector: {requester[1:0], op[1:0], addr[3:0], wdata[7:0], expected rsp[7:0]}
  localparam int NV = 11;
  localparam logic [23:0] VEC [NV] = '{
    {2'd0, 2'b00, 4'd3, 8'h00, 8'h00},  // R1 reset word is 0, R4 load
    {2'd1, 2'b01, 4'd3, 8'h5A, 8'h00},  // R5 store answers 0
    {2'd2, 2'b00, 4'd3, 8'h00, 8'h5A},  // R4 load sees stored word
    {2'd3, 2'b10, 4'd3, 8'h01, 8'h5A},  // R6 swap returns old word
    {2'd0, 2'b00, 4'd3, 8'h00, 8'h01},  // R6 new word in place
    {2'd1, 2'b11, 4'd3, 8'hFF, 8'h01},  // R9 peek returns word
    {2'd2, 2'b00, 4'd3, 8'h00, 8'h01},  // R9 peek wrote nothing
    {2'd0, 2'b10, 4'd7, 8'h01, 8'h00},  // R6 acquire free lock
    {2'd1, 2'b10, 4'd7, 8'h01, 8'h01},  // R6 lock held: retry
    {2'd0, 2'b01, 4'd7, 8'h00, 8'h00},  // R5 release
    {2'd1, 2'b10, 4'd7, 8'h01, 8'h00}   // R6 acquire after release
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setReq(input int r, input logic [1:0] op, input logic [A-1:0] a,
                        input logic [D-1:0] d);
    reqValid[r]        = 1'b1;
    reqOp[r*2 +: 2]    = op;
    reqAddr[r*A +: A]  = a;
    reqWdata[r*D +: D] = d;
  endtask

  initial begin
    #(20 * 2000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rspValid == '0, "R1 rspValid in reset", rspValid, 0);
    check(reqGrant == '0, "R1 grant idle", reqGrant, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(rspValid == '0, "R1 rspValid after reset", rspValid, 0);

    // table walk: one requester at a time
    for (int v = 0; v < NV; v++) begin
      int r;
      r = int'(VEC[v][23:22]);
      reqValid = '0;
      setReq(r, VEC[v][21:20], VEC[v][18:16], VEC[v][15:8]);
      #2;
      check(reqGrant == N'(1 << r), "R2 grant", reqGrant, 1 << r);
      @(negedge clk);
      check(rspValid == N'(1 << r), "R8 rspValid", rspValid, 1 << r);
      check(rspData == VEC[v][7:0], "R4/R5/R6/R9 rspData", rspData, VEC[v][7:0]);
      reqValid = '0;
      @(negedge clk);
      check(rspValid == '0, "R8 single pulse", rspValid, 0);
    end

    // R7: two swaps on the same free lock in the same cycle
    begin
      int g1, g2;
      logic [D-1:0] d1, d2;
      reqValid = '0;
      setReq(1, 2'b10, 3'd5, 8'h01);
      setReq(2, 2'b10, 3'd5, 8'h01);
      #2;
      check($countones(reqGrant) == 1, "R7 one grant", reqGrant, 1);
      g1 = (reqGrant[1]) ? 1 : 2;
      @(negedge clk);
      d1 = rspData;
      check(rspValid == N'(1 << g1), "R8 first racer rsp", rspValid, 1 << g1);
      reqValid[g1] = 1'b0;
      #2;
      g2 = (g1 == 1) ? 2 : 1;
      check(reqGrant == N'(1 << g2), "R7 loser granted next", reqGrant, 1 << g2);
      @(negedge clk);
      d2 = rspData;
      reqValid = '0;
      check((d1 == 8'h00) != (d2 == 8'h00), "R7 exactly one zero", {d1, d2}, 0);
      check(((d1 == 8'h00) && (d2 == 8'h01)) || ((d1 == 8'h01) && (d2 == 8'h00)),
            "R7 loser sees 1", {d1, d2}, 16'h0001);
      @(negedge clk);
    end

    // R3: all requesters load continuously, grants must rotate
    begin
      int prev;
      logic [N-1:0] lastGrant;
      prev = -1;
      reqValid = '0;
      for (int r = 0; r < N; r++) setReq(r, 2'b00, 3'd0, 8'h00);
      for (int c = 0; c < 8; c++) begin
        int g;
        #2;
        g = 0;
        for (int r = 0; r < N; r++) if (reqGrant[r]) g = r;
        check($countones(reqGrant) == 1, "R2 one grant under load", reqGrant, 1);
        if (prev >= 0) check(g == (prev + 1) % N, "R3 rotation", g, (prev + 1) % N);
        prev = g;
        lastGrant = reqGrant;
        @(negedge clk);
        check(rspValid == lastGrant, "R8 rsp to granted", rspValid, lastGrant);
      end
      reqValid = '0;
      @(negedge clk);
      check(reqGrant == '0, "R2 no grant idle", reqGrant, 0);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule